// File: doc/BRIEF.md
# T1 Remote Alarm Detector

This block watches a framed T1 receive stream and reports when the far end signals a remote (yellow) alarm. The framer ahead of it supplies one data bit per clock with strobes: a strobe for each channel bit with that bit's position in its channel, and a strobe for the framing (S) bit with the number of the frame within the superframe. The detector has two methods, chosen by a mode input. In the channel method it watches the second bit of every channel. In the superframe method it watches the S-bit of the last frame of each 12-frame superframe.

The result is a level alarm flag and a single-cycle event pulse. The pulse marks each raise and each drop of the flag. While the framer reports that it is not in sync, the detector freezes. It ignores the stream until sync returns.

Top module: `yel_alarm_det`

## Requirements
- R1: After reset, `alarm` and `alarmEvent` are both 0 and no run history is held.
- R2: In channel mode (`modeSbit`=0), `alarm` rises on the clock edge that samples the 256th consecutive channel whose bit at `bitPos`=1 (the second bit of the channel; positions 0 to 7 in arrival order) is 1.
- R3: A channel whose second bit is 0 restarts the run, so a later declaration needs 256 new channels. Once the run reaches 256 it saturates, and further 1s cause no further event.
- R4: In channel mode, while `alarm` is 1, the first channel whose second bit is 0 clears `alarm` on the edge that samples that bit.
- R5: `alarmEvent` is 1 for exactly the one cycle that follows each edge where `alarm` changes, and 0 otherwise.
- R6: In channel mode, bits at positions other than 1 and all S-bit strobes have no effect on `alarm`.
- R7: While `syncValid` is 0, `alarm` and all run history hold their values and every strobe is ignored.
- R8: In superframe mode (`modeSbit`=1), `alarm` rises on the edge that samples the second consecutive frame-12 S-bit equal to 1 (`frameNum` counts 1 to 12). S-bits of other frames are ignored.
- R9: In superframe mode, `alarm` clears on the edge that samples the second consecutive frame-12 S-bit equal to 0.
- R10: In superframe mode, channel bits have no effect on `alarm`. The history of the inactive method is held unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| syncValid | input | 1 | Framer in sync; when 0 the detector freezes |
| modeSbit | input | 1 | 0 = channel second-bit method, 1 = frame-12 S-bit method |
| bitStrobe | input | 1 | A channel bit is present on `bitData` |
| bitPos | input | 3 | Position of the current bit within its channel, 0 to 7 |
| bitData | input | 1 | Stream bit (channel bit or S-bit) |
| sBitStrobe | input | 1 | An S-bit is present on `bitData` |
| frameNum | input | 4 | Frame number within the superframe, 1 to 12 |
| alarm | output | 1 | Remote alarm flag |
| alarmEvent | output | 1 | One-cycle pulse on each raise or drop of `alarm` |

## Verification
Two functions share a cycle when the 256th set second bit arrives. On that edge the run counter reaches its cap and the alarm is declared. The bench drives runs of exactly 255, 256 and well over 256 channels. It judges that the flag and its pulse appear on that edge, and that the saturated counter produces no second pulse. The same overlap is provoked in reverse: a zero second bit arrives while alarmed, so one edge both empties the run and drops the flag. A behavioural model checks both cases on every clock.

// File: rtl/yel_pkg.sv
package yel_pkg;
  // Decoded per-cycle strobes passed from control to datapath.
  typedef struct packed {
    logic runInc;  // qualified channel second bit = 1
    logic runClr;  // qualified channel second bit = 0
    logic sOne;    // qualified frame-12 S-bit = 1
    logic sZero;   // qualified frame-12 S-bit = 0
  } yelStrobe_t;
endpackage

// File: rtl/yel_dp.sv
module yel_dp #(
  parameter int RUN_LEN = 256,
  parameter int S_RUN   = 2,
  localparam int RUN_W  = $clog2(RUN_LEN + 1),
  localparam int SRUN_W = $clog2(S_RUN + 1)
) (
  input  logic                clk,
  input  logic                rstN,
  input  yel_pkg::yelStrobe_t strb,
  output logic [RUN_W-1:0]    runCnt,
  output logic [SRUN_W-1:0]   oneCnt,
  output logic [SRUN_W-1:0]   zeroCnt
);
  localparam logic [RUN_W-1:0]  RUN_CAP = RUN_W'(RUN_LEN);
  localparam logic [SRUN_W-1:0] S_CAP   = SRUN_W'(S_RUN);

  // Saturating run of consecutive set second bits.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                              runCnt <= '0;
    else if (strb.runClr)                   runCnt <= '0;
    else if (strb.runInc && runCnt != RUN_CAP) runCnt <= runCnt + 1'b1;
  end

  // Consecutive frame-12 S-bit ones and zeros, each saturating.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      oneCnt  <= '0;
      zeroCnt <= '0;
    end else if (strb.sOne) begin
      zeroCnt <= '0;
      if (oneCnt != S_CAP) oneCnt <= oneCnt + 1'b1;
    end else if (strb.sZero) begin
      oneCnt <= '0;
      if (zeroCnt != S_CAP) zeroCnt <= zeroCnt + 1'b1;
    end
  end

  AST_RUN_CAP:    assert property (@(posedge clk) disable iff (!rstN) runCnt <= RUN_CAP); // R3
  AST_BREAK_ZERO: assert property (@(posedge clk) disable iff (!rstN) strb.runClr |=> runCnt == '0); // R3
  AST_SRUN_CAP:   assert property (@(posedge clk) disable iff (!rstN) (oneCnt <= S_CAP) && (zeroCnt <= S_CAP)); // R8
  AST_S_EXCL:     assert property (@(posedge clk) disable iff (!rstN) strb.sOne |=> zeroCnt == '0); // R9
endmodule

// File: rtl/yel_ctrl.sv
module yel_ctrl #(
  parameter int RUN_LEN       = 256,
  parameter int S_RUN         = 2,
  parameter int BITS_PER_CH   = 8,
  parameter int FRAMES_PER_SF = 12,
  parameter int BIT2_IDX      = 1,
  localparam int RUN_W  = $clog2(RUN_LEN + 1),
  localparam int SRUN_W = $clog2(S_RUN + 1),
  localparam int POS_W  = $clog2(BITS_PER_CH),
  localparam int FRM_W  = $clog2(FRAMES_PER_SF + 1)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                syncValid,
  input  logic                modeSbit,
  input  logic                bitStrobe,
  input  logic [POS_W-1:0]    bitPos,
  input  logic                bitData,
  input  logic                sBitStrobe,
  input  logic [FRM_W-1:0]    frameNum,
  input  logic [RUN_W-1:0]    runCnt,
  input  logic [SRUN_W-1:0]   oneCnt,
  input  logic [SRUN_W-1:0]   zeroCnt,
  output yel_pkg::yelStrobe_t strb,
  output logic                alarm,
  output logic                alarmEvent
);
  localparam logic [RUN_W-1:0]  RUN_LAST = RUN_W'(RUN_LEN - 1);
  localparam logic [SRUN_W-1:0] S_LAST   = SRUN_W'(S_RUN - 1);
  localparam logic [POS_W-1:0]  WATCH_POS = POS_W'(BIT2_IDX);
  localparam logic [FRM_W-1:0]  WATCH_FRM = FRM_W'(FRAMES_PER_SF);

  logic chanHit;
  logic sHit;
  logic declare;
  logic release_;

  assign chanHit = syncValid && !modeSbit && bitStrobe && (bitPos == WATCH_POS);
  assign sHit    = syncValid && modeSbit && sBitStrobe && (frameNum == WATCH_FRM);

  always_comb begin
    strb.runInc = chanHit && bitData;
    strb.runClr = chanHit && !bitData;
    strb.sOne   = sHit && bitData;
    strb.sZero  = sHit && !bitData;
  end

  // Decide on the edge that completes a run, using the count before it.
  assign declare  = !alarm && ((strb.runInc && runCnt >= RUN_LAST) ||
                               (strb.sOne && oneCnt >= S_LAST));
  assign release_ = alarm && (strb.runClr || (strb.sZero && zeroCnt >= S_LAST));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      alarm      <= 1'b0;
      alarmEvent <= 1'b0;
    end else begin
      alarmEvent <= declare || release_;
      if (declare)       alarm <= 1'b1;
      else if (release_) alarm <= 1'b0;
    end
  end

  AST_DECLARE_RUN: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(alarm) && !$past(modeSbit)) |-> runCnt == RUN_W'(RUN_LEN)); // R2
  AST_EVENT_MATCH: assert property (@(posedge clk) disable iff (!rstN)
    (alarm != $past(alarm)) |-> alarmEvent); // R5
  AST_NOSYNC_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !syncValid |=> $stable(alarm)); // R7
  AST_SMODE_DECL:  assert property (@(posedge clk) disable iff (!rstN)
    ($rose(alarm) && $past(modeSbit)) |-> oneCnt == SRUN_W'(S_RUN)); // R8
endmodule

// File: rtl/yel_alarm_det.sv
module yel_alarm_det #(
  parameter int RUN_LEN       = 256,
  parameter int S_RUN         = 2,
  parameter int BITS_PER_CH   = 8,
  parameter int FRAMES_PER_SF = 12,
  parameter int BIT2_IDX      = 1,
  localparam int RUN_W  = $clog2(RUN_LEN + 1),
  localparam int SRUN_W = $clog2(S_RUN + 1),
  localparam int POS_W  = $clog2(BITS_PER_CH),
  localparam int FRM_W  = $clog2(FRAMES_PER_SF + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             syncValid,
  input  logic             modeSbit,
  input  logic             bitStrobe,
  input  logic [POS_W-1:0] bitPos,
  input  logic             bitData,
  input  logic             sBitStrobe,
  input  logic [FRM_W-1:0] frameNum,
  output logic             alarm,
  output logic             alarmEvent
);
  yel_pkg::yelStrobe_t strb;
  logic [RUN_W-1:0]  runCnt;
  logic [SRUN_W-1:0] oneCnt;
  logic [SRUN_W-1:0] zeroCnt;

  yel_ctrl #(
    .RUN_LEN(RUN_LEN), .S_RUN(S_RUN), .BITS_PER_CH(BITS_PER_CH),
    .FRAMES_PER_SF(FRAMES_PER_SF), .BIT2_IDX(BIT2_IDX)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .syncValid(syncValid), .modeSbit(modeSbit),
    .bitStrobe(bitStrobe), .bitPos(bitPos), .bitData(bitData),
    .sBitStrobe(sBitStrobe), .frameNum(frameNum),
    .runCnt(runCnt), .oneCnt(oneCnt), .zeroCnt(zeroCnt),
    .strb(strb), .alarm(alarm), .alarmEvent(alarmEvent)
  );

  yel_dp #(.RUN_LEN(RUN_LEN), .S_RUN(S_RUN)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .runCnt(runCnt), .oneCnt(oneCnt), .zeroCnt(zeroCnt)
  );
endmodule

// File: tb/yel_alarm_det_tb.sv
module yel_alarm_det_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       syncValid = 1'b0;
  logic       modeSbit = 1'b0;
  logic       bitStrobe = 1'b0;
  logic [2:0] bitPos = '0;
  logic       bitData = 1'b0;
  logic       sBitStrobe = 1'b0;
  logic [3:0] frameNum = 4'd1;
  logic       alarm;
  logic       alarmEvent;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // Reference model state
  int  mRun = 0, mOnes = 0, mZeros = 0;
  bit  mAlarm = 0, mEvt = 0;
  int  mEvtCount = 0, seenEvtCount = 0;

  always #10 clk = ~clk;  // 50 MHz

  yel_alarm_det u_dut (
    .clk(clk), .rstN(rstN), .syncValid(syncValid), .modeSbit(modeSbit),
    .bitStrobe(bitStrobe), .bitPos(bitPos), .bitData(bitData),
    .sBitStrobe(sBitStrobe), .frameNum(frameNum),
    .alarm(alarm), .alarmEvent(alarmEvent)
  );

  // Behavioural model, updated on the same edge the design registers.
  always @(posedge clk) begin
    if (!rstN) begin
      mRun = 0; mOnes = 0; mZeros = 0; mAlarm = 0; mEvt = 0;
    end else begin
      mEvt = 0;
      if (syncValid && !modeSbit && bitStrobe && bitPos == 3'd1) begin
        if (bitData) begin
          if (mRun < 256) mRun++;
          if (mRun == 256 && !mAlarm) begin mAlarm = 1; mEvt = 1; end
        end else begin
          mRun = 0;
          if (mAlarm) begin mAlarm = 0; mEvt = 1; end
        end
      end
      if (syncValid && modeSbit && sBitStrobe && frameNum == 4'd12) begin
        if (bitData) begin
          mZeros = 0; mOnes++;
          if (mOnes >= 2 && !mAlarm) begin mAlarm = 1; mEvt = 1; end
        end else begin
          mOnes = 0; mZeros++;
          if (mZeros >= 2 && mAlarm) begin mAlarm = 0; mEvt = 1; end
        end
      end
      if (mEvt) mEvtCount++;
    end
  end

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  // Every-clock comparison against the model (R2 R4 R5 R8 R9 checked here too).
  always @(negedge clk) begin
    if (rstN && !done) begin
      check("model alarm R2 R4 R8 R9", alarm, mAlarm);
      check("model event R5", alarmEvent, mEvt);
      if (alarmEvent === 1'b1) seenEvtCount++;
    end
  end

  task automatic idle();
    @(negedge clk);
    bitStrobe = 0; sBitStrobe = 0;
  endtask

  // One channel: position 1 carries b2, the other seven carry its opposite.
  task automatic sendChans(input int n, input logic b2);
    for (int c = 0; c < n; c++) begin
      for (int k = 0; k < 8; k++) begin
        @(negedge clk);
        sBitStrobe = 0; bitStrobe = 1;
        bitPos = 3'(k);
        bitData = (k == 1) ? b2 : ~b2;
      end
    end
  endtask

  task automatic sendS(input int frm, input logic v);
    @(negedge clk);
    bitStrobe = 0; sBitStrobe = 1;
    frameNum = 4'(frm);
    bitData = v;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("reset alarm R1", alarm, 1'b0);
    check("reset event R1", alarmEvent, 1'b0);
    rstN = 1; syncValid = 1; modeSbit = 0;
    idle();
    check("post-reset alarm R1", alarm, 1'b0);

    // R6: S-bits ignored in channel mode
    sendS(12, 1); sendS(12, 1); sendS(12, 1); idle();
    check("S-bits ignored in channel mode R6", alarm, 1'b0);

    // R2: 255 is not enough, 256 declares (saturation and declare coincide)
    sendChans(255, 1); idle();
    check("255 channels no alarm R2", alarm, 1'b0);
    sendChans(1, 1); idle();
    check("256th channel declares R2", alarm, 1'b1);

    // R3: saturated run, no new event
    sendChans(300, 1); idle();
    check("saturated run stays alarmed R3", alarm, 1'b1);

    // R7: sync low freezes
    syncValid = 0;
    sendChans(3, 0); idle();
    check("sync low ignores break R7", alarm, 1'b1);
    syncValid = 1;

    // R4: first break clears
    sendChans(1, 0); idle();
    check("first break clears R4", alarm, 1'b0);

    // R3 and R6: broken run restarts; other bits set do nothing
    sendChans(200, 1); sendChans(1, 0); sendChans(255, 1); idle();
    check("restarted run not yet full R3", alarm, 1'b0);
    sendChans(1, 1); idle();
    check("restarted run declares R2", alarm, 1'b1);
    sendChans(1, 0); sendChans(20, 0); idle();
    check("non-bit-2 ones ignored R6", alarm, 1'b0);

    // R7: sync low during a run holds the count
    sendChans(100, 1);
    syncValid = 0; sendChans(50, 0); syncValid = 1;
    sendChans(156, 1); idle();
    check("run held across sync loss R7", alarm, 1'b1);

    // R10: superframe mode ignores channel bits
    modeSbit = 1;
    sendChans(5, 0); idle();
    check("channel bits ignored in S mode R10", alarm, 1'b1);

    // R9: one zero not enough, other frames ignored, second zero clears
    sendS(12, 0); sendS(7, 0); sendS(7, 1); idle();
    check("single frame-12 zero R9", alarm, 1'b1);
    sendS(12, 0); idle();
    check("second frame-12 zero clears R9", alarm, 1'b0);

    // R8: one one, channel ones between, second one declares
    sendS(12, 1); sendChans(300, 1); sendS(3, 0); idle();
    check("single frame-12 one R8", alarm, 1'b0);
    sendS(12, 1); idle();
    check("second frame-12 one declares R8", alarm, 1'b1);

    // R7 in superframe mode
    syncValid = 0;
    sendS(12, 0); sendS(12, 0); idle();
    check("sync low ignores S-bits R7", alarm, 1'b1);
    syncValid = 1;

    // R10: channel history held while in S mode; back in channel mode a break clears
    modeSbit = 0;
    sendChans(1, 0); idle();
    check("channel break after mode return R10", alarm, 1'b0);

    repeat (3) idle();
    check("event pulse count R5", seenEvtCount[0], mEvtCount[0]);
    checks++;
    if (seenEvtCount != mEvtCount) begin
      failures++;
      $display("FAIL R5 event total actual=%0d expected=%0d", seenEvtCount, mEvtCount);
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      failures++;
      $display("FAIL watchdog R1 actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule